// File: doc/BRIEF.md
# Length-Prefixed Frame Capture Engine

This block sits behind a serial receive shifter and turns its byte stream into one stored frame per transfer. Each frame opens with a two-byte length header, most significant byte first. The header bytes and the payload that follows are written into a local byte buffer, and a done flag then goes high. A frame that cannot fit in the buffer is refused without any write and is flagged as rejected. Once a frame has completed or been refused, the block ignores further bytes until the chip-select deassertion event (`cs_end`) re-arms it. The stored frame can be read back byte by byte, for example to echo it to the host.

Bytes enter on a valid/ready port. A byte is taken on a clock edge where both `in_valid` and `in_ready` are high and `cs_end` is low. `in_ready` is low for exactly one cycle, the cycle after the second header byte of a frame that fits, while the second header byte is written. It is high at all other times, including while bytes are being discarded. The sender must hold `in_valid` and `in_data` steady while `in_ready` is low. Each new frame starts at a buffer offset that rotates through 0, 1 and 2, so that later consumers see different alignments.

Top module: `frame_capture`

## Requirements
- R1: After reset, `frame_done`, `frame_reject` and `frame_count` are 0, `frame_base` is 0 and `in_ready` is 1.
- R2: The payload length is `hdr0*256 + hdr1`, where hdr0 is the first byte accepted and hdr1 the second. The stored frame holds that length plus 2 bytes. `frame_count` counts the bytes stored so far in the current frame.
- R3: The header bytes are stored first, and payload bytes follow in arrival order. `frame_done` rises on the edge that stores the last byte. When the length is 0, it rises one cycle after the second header byte.
- R4: A frame is oversize when start offset + length + 2 exceeds DEPTH (1100). An oversize frame goes straight to the rejected state on its second header byte, stores nothing, and keeps `frame_count` at 0.
- R5: While done or rejected, the block still accepts bytes (`in_ready` high) but discards them. `frame_count`, the flags and the buffer contents do not change.
- R6: A `cs_end` pulse returns the block to idle from any state on the next edge. It clears `frame_done`, `frame_reject` and `frame_count`, and it abandons a partial frame. A byte presented in the same cycle as `cs_end` is dropped.
- R7: When fewer than two header bytes arrive before `cs_end`, nothing is stored. The next transfer parses a fresh two-byte header.
- R8: On every second header byte, the start offset `frame_base` moves to (previous + 1) mod 3, so the first frame after reset starts at offset 1. This applies to oversize frames as well.
- R9: `in_ready` goes low for exactly one cycle after the second header byte of a frame that fits, and is high otherwise.
- R10: `rd_data` returns, one cycle after `rd_addr` is applied, the stored byte at position `rd_addr` counted from the first header byte of the current frame.
- R11: At the boundary, a frame whose start offset plus total size equals exactly DEPTH is accepted and fills the buffer to its last entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block can take a byte this cycle |
| cs_end | input | 1 | One-cycle chip-select deassertion event |
| frame_done | output | 1 | Complete frame stored |
| frame_reject | output | 1 | Oversize frame refused |
| frame_count | output | 11 | Bytes stored for the current frame |
| frame_base | output | 2 | Buffer offset of the current frame's first byte |
| rd_addr | input | 11 | Readback byte index within the frame |
| rd_data | output | 8 | Readback byte, one cycle latency |

## Verification
A behavioural reference model steps alongside the design and is compared every cycle. It is exercised with several frame patterns:
- Short frames sent back to back and with gaps in `in_valid`, which separate correct header parsing from off-by-one counting.
- A zero-length frame, which checks that completion happens straight after the header.
- A single header byte followed by `cs_end`, and an abandoned partial frame, which test re-arming without any stored bytes.
- An oversize header, and a frame that exactly fills the buffer at offset 1 next to the same length at offset 2, which bound the fit check from both sides.
- Bytes sent after completion, which must leave the count and the readback of the frame unchanged.

// File: rtl/frame_cap_pkg.sv
package frame_cap_pkg;
  typedef enum logic [1:0] {
    FC_IDLE   = 2'd0,
    FC_HDR_WR = 2'd1,
    FC_RECV   = 2'd2,
    FC_DONE   = 2'd3
  } fc_state_e;
endpackage

// File: rtl/frame_hdr_decode.sv
module frame_hdr_decode #(
  parameter int DEPTH  = 1100,
  parameter int ROT_N  = 3,
  parameter int SIZE_W = 17,
  parameter int BASE_W = 2
) (
  input  logic [7:0]        hdr_hi,
  input  logic [7:0]        hdr_lo,
  input  logic [BASE_W-1:0] base_cur,
  output logic [SIZE_W-1:0] total_size,
  output logic [BASE_W-1:0] base_next,
  output logic              fits
);
  localparam logic [SIZE_W:0] DEPTH_X = DEPTH;
  logic [SIZE_W:0] end_pos;

  always_comb begin
    total_size = SIZE_W'({hdr_hi, hdr_lo}) + SIZE_W'(2);
    if (base_cur == BASE_W'(ROT_N - 1)) base_next = '0;
    else                                base_next = base_cur + BASE_W'(1);
    end_pos = (SIZE_W+1)'(base_next) + {1'b0, total_size};
    fits    = (end_pos <= DEPTH_X);
  end
endmodule

// File: rtl/frame_buf.sv
module frame_buf #(
  parameter int DEPTH  = 1100,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W:0]   rd_idx,
  output logic [7:0]        rd_data
);
  localparam logic [ADDR_W:0] DEPTH_X = DEPTH;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                rd_data <= '0;
    else if (rd_idx < DEPTH_X) rd_data <= mem[rd_idx[ADDR_W-1:0]];
    else                       rd_data <= '0;
  end

  // R4
  wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ({1'b0, wr_addr} < DEPTH_X));
endmodule

// File: rtl/frame_capture.sv
module frame_capture #(
  parameter int DEPTH = 1100,
  parameter int ROT_N = 3,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int BASE_W = $clog2(ROT_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  input  logic              cs_end,
  output logic              frame_done,
  output logic              frame_reject,
  output logic [CNT_W-1:0]  frame_count,
  output logic [BASE_W-1:0] frame_base,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  import frame_cap_pkg::*;
  localparam int SIZE_W = 17;

  fc_state_e         state_q;
  logic [7:0]        hi_q, lo_q;
  logic              hcnt_q, valid_q;
  logic [BASE_W-1:0] base_q, base_next;
  logic [ADDR_W-1:0] wr_ptr_q;
  logic [SIZE_W-1:0] rem_q, total_size;
  logic [CNT_W-1:0]  cnt_q;
  logic              fits, accept;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;
  logic [ADDR_W:0]   rd_idx;

  frame_hdr_decode #(.DEPTH(DEPTH), .ROT_N(ROT_N), .SIZE_W(SIZE_W), .BASE_W(BASE_W)) hdr_i (
    .hdr_hi(hi_q), .hdr_lo(in_data), .base_cur(base_q),
    .total_size(total_size), .base_next(base_next), .fits(fits)
  );

  assign in_ready = (state_q != FC_HDR_WR);
  assign accept   = in_valid && in_ready && !cs_end;

  always_comb begin
    wr_en   = 1'b0;
    wr_addr = wr_ptr_q;
    wr_data = in_data;
    unique case (state_q)
      FC_IDLE: if (accept && hcnt_q && fits) begin
        wr_en   = 1'b1;
        wr_addr = ADDR_W'(base_next);
        wr_data = hi_q;
      end
      FC_HDR_WR: if (!cs_end) begin
        wr_en   = 1'b1;
        wr_data = lo_q;
      end
      FC_RECV: wr_en = accept;
      default: wr_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= FC_IDLE;
      hi_q     <= '0;
      lo_q     <= '0;
      hcnt_q   <= 1'b0;
      valid_q  <= 1'b0;
      base_q   <= '0;
      wr_ptr_q <= '0;
      rem_q    <= '0;
      cnt_q    <= '0;
    end else if (cs_end) begin
      state_q <= FC_IDLE;
      hcnt_q  <= 1'b0;
      valid_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        FC_IDLE: if (accept) begin
          if (!hcnt_q) begin
            hi_q   <= in_data;
            hcnt_q <= 1'b1;
          end else begin
            hcnt_q <= 1'b0;
            base_q <= base_next;
            if (fits) begin
              lo_q     <= in_data;
              wr_ptr_q <= ADDR_W'(base_next) + ADDR_W'(1);
              cnt_q    <= CNT_W'(1);
              rem_q    <= total_size - SIZE_W'(2);
              state_q  <= FC_HDR_WR;
            end else begin
              valid_q <= 1'b0;
              state_q <= FC_DONE;
            end
          end
        end
        FC_HDR_WR: begin
          cnt_q    <= CNT_W'(2);
          wr_ptr_q <= wr_ptr_q + ADDR_W'(1);
          if (rem_q == '0) begin
            valid_q <= 1'b1;
            state_q <= FC_DONE;
          end else begin
            state_q <= FC_RECV;
          end
        end
        FC_RECV: if (accept) begin
          cnt_q    <= cnt_q + CNT_W'(1);
          wr_ptr_q <= wr_ptr_q + ADDR_W'(1);
          rem_q    <= rem_q - SIZE_W'(1);
          if (rem_q == SIZE_W'(1)) begin
            valid_q <= 1'b1;
            state_q <= FC_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  assign rd_idx = (ADDR_W+1)'(base_q) + {1'b0, rd_addr};

  frame_buf #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) buf_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  assign frame_done   = (state_q == FC_DONE) && valid_q;
  assign frame_reject = (state_q == FC_DONE) && !valid_q;
  assign frame_count  = cnt_q;
  assign frame_base   = base_q;

  // R9
  stall_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready);
  // R6
  cs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_end |=> (frame_count == '0 && !frame_done && !frame_reject));
  // R5
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !cs_end) |=> (frame_done && $stable(frame_count)));
  // R4
  reject_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_reject |-> (frame_count == '0));
  // R8
  base_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(frame_base) < ROT_N);
  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(frame_count) <= DEPTH);
endmodule

// File: tb/frame_capture_tb_top.sv
module frame_capture_tb_top;
  localparam int DEPTH = 1100;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, cs_end;
  logic [7:0]  in_data;
  logic        in_ready, frame_done, frame_reject;
  logic [10:0] frame_count, rd_addr;
  logic [1:0]  frame_base;
  logic [7:0]  rd_data;

  always #4 clk = ~clk;

  frame_capture dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .cs_end(cs_end), .frame_done(frame_done),
    .frame_reject(frame_reject), .frame_count(frame_count),
    .frame_base(frame_base), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int tests = 0, fails = 0;
  // model: 0 idle, 1 header write, 2 receiving, 3 finished
  int m_state = 0, m_hcnt = 0, m_hi = 0, m_lo = 0, m_base = 0;
  int m_valid = 0, m_cnt = 0, m_rem = 0;
  logic [7:0] m_mem [DEPTH];

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_step(input bit acc, input logic [7:0] d, input bit cs);
    int size, nb;
    if (cs) begin
      m_state = 0; m_hcnt = 0; m_valid = 0; m_cnt = 0;
    end else if (m_state == 0) begin
      if (acc) begin
        if (m_hcnt == 0) begin
          m_hi = d; m_hcnt = 1;
        end else begin
          m_hcnt = 0;
          size = m_hi * 256 + d + 2;
          nb = (m_base + 1) % 3;
          m_base = nb;
          if (nb + size <= DEPTH) begin
            m_mem[nb] = m_hi[7:0]; m_lo = d; m_cnt = 1; m_rem = size - 2; m_state = 1;
          end else begin
            m_valid = 0; m_state = 3;
          end
        end
      end
    end else if (m_state == 1) begin
      m_mem[m_base + 1] = m_lo[7:0]; m_cnt = 2;
      if (m_rem == 0) begin m_valid = 1; m_state = 3; end
      else m_state = 2;
    end else if (m_state == 2) begin
      if (acc) begin
        m_mem[m_base + m_cnt] = d; m_cnt++; m_rem--;
        if (m_rem == 0) begin m_valid = 1; m_state = 3; end
      end
    end
  endtask

  task automatic cyc(input bit v, input logic [7:0] d, input bit cs, output bit acc);
    in_valid = v; in_data = d; cs_end = cs;
    acc = v && (m_state != 1) && !cs;
    model_step(acc, d, cs);
    @(negedge clk);
    chk("R9 in_ready", int'(in_ready), int'(m_state != 1));
    chk("R3 frame_done", int'(frame_done), int'(m_state == 3 && m_valid == 1));
    chk("R4 frame_reject", int'(frame_reject), int'(m_state == 3 && m_valid == 0));
    chk("R2 frame_count", int'(frame_count), m_cnt);
    chk("R8 frame_base", int'(frame_base), m_base);
  endtask

  task automatic send(input logic [7:0] d);
    bit acc;
    do cyc(1'b1, d, 1'b0, acc); while (!acc);
  endtask

  task automatic idle(input int n);
    bit acc;
    for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 1'b0, acc);
  endtask

  task automatic cs_pulse();
    bit acc;
    cyc(1'b0, 8'h00, 1'b1, acc);
    idle(1);
  endtask

  task automatic send_frame(input int len, input bit gaps);
    send(8'(len >> 8));
    send(8'(len));
    for (int i = 0; i < len; i++) begin
      send(8'(i * 7 + len));
      if (gaps && (i % 3 == 1)) idle(1);
    end
    idle(2);
  endtask

  task automatic readback(input string req);
    in_valid = 1'b0; cs_end = 1'b0;
    for (int i = 0; i < m_cnt; i++) begin
      rd_addr = 11'(i);
      @(negedge clk);
      chk(req, int'(rd_data), int'(m_mem[m_base + i]));
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit acc;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; cs_end = 1'b0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 done", int'(frame_done), 0);
    chk("R1 reject", int'(frame_reject), 0);
    chk("R1 count", int'(frame_count), 0);
    chk("R1 base", int'(frame_base), 0);
    chk("R1 ready", int'(in_ready), 1);

    // R2 R3 R10: short frame with gaps, offset 1
    send_frame(5, 1'b1);
    chk("R3 done after 7 bytes", int'(frame_done), 1);
    readback("R10 readback frame A");
    // R5: extra bytes discarded
    for (int i = 0; i < 4; i++) send(8'hE0 + 8'(i));
    chk("R5 count held", int'(frame_count), 7);
    readback("R5 frame A intact");
    cs_pulse();

    // R3 zero-length frame, back to back
    send_frame(0, 1'b0);
    chk("R3 zero-length done", int'(frame_done), 1);
    chk("R3 zero-length count", int'(frame_count), 2);
    readback("R10 readback header only");
    cs_pulse();

    // R7: one header byte then deassert
    send(8'h00);
    cs_pulse();
    chk("R7 still idle", int'(frame_count), 0);
    send_frame(3, 1'b0);
    chk("R7 fresh header parsed", int'(frame_count), 5);
    readback("R10 readback frame C");
    cs_pulse();

    // R6: partial frame abandoned, byte in cs cycle dropped
    send(8'h00); send(8'd10);
    send(8'h11); send(8'h22);
    cyc(1'b1, 8'h33, 1'b1, acc);
    idle(1);
    chk("R6 partial cleared", int'(frame_count), 0);
    send_frame(2, 1'b1);
    readback("R6 new frame after abandon");
    cs_pulse();

    // R4 oversize reject
    send(8'hFF); send(8'hFF);
    idle(1);
    chk("R4 reject", int'(frame_reject), 1);
    send(8'h55);
    chk("R5 ignore while rejected", int'(frame_count), 0);
    cs_pulse();

    // R11 exact fit at offset 1
    send_frame(1097, 1'b0);
    chk("R11 exact fit done", int'(frame_done), 1);
    chk("R11 exact fit count", int'(frame_count), 1099);
    readback("R11 readback full buffer");
    cs_pulse();

    // R4 R11 same length at offset 2 is refused
    send(8'(1097 >> 8)); send(8'(1097));
    idle(1);
    chk("R4 boundary reject", int'(frame_reject), 1);
    cs_pulse();

    // R8 rotation wraps to 0 again
    send_frame(1, 1'b0);
    chk("R8 base wrap", int'(frame_base), 0);
    readback("R10 readback offset 0");
    cs_pulse();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule